// File: doc/BRIEF.md
# TMDS Serializer PHY Bring-up and Shutdown Sequencer

This block is the control engine that starts and stops a TMDS serializer PHY. A start pulse comes with the pixel clock frequency in hertz. The block looks up the frequency band and picks the PLL reference and post divider codes for that band. It then programs the PLL through a one-cycle register write port and waits for the PLL to report lock. The wait ends early when lock appears and is otherwise bounded by a cycle timeout. Once locked, it writes the serializer configuration, then clears the current-control register and then the calibration register.

A stop pulse takes the PHY down. The block writes the serializer configuration with only the two detection circuits left on, then writes zero to the PLL configuration register. It waits for lock to drop under the same timeout and reports an error if the PLL still claims lock. Every sequence ends with a one-cycle `done` or `error` pulse, and `busy` marks the time in between.

Top module: `tmds_phy_seq`

## Requirements
- R1: An accepted start issues a single write to address 0x510 with data {6'b0, post_code[1:0], ref_div[7:0], 8'd40, 7'b0, 1'b1}. The band is chosen by pixel frequency f, with each band's lower bound inclusive and its upper bound exclusive:
  - f < 20 MHz: ref_div 1, post_code 3.
  - 20 MHz to 42.5 MHz: ref_div 2, post_code 3.
  - 42.5 MHz to 85 MHz: ref_div 4, post_code 2.
  - 85 MHz to 170 MHz: ref_div 8, post_code 1.
  - 170 MHz to 340 MHz: ref_div 16, post_code 0.
- R2: A start with f of 340 MHz or more performs no register write. It raises `err_o` in the cycle after the start pulse, and `busy_o` stays low.
- R3: After the PLL write the block waits until `lock_i` is high, or for TIMEOUT_CYC cycles if it never is. If lock is absent when the wait ends, it pulses `err_o` without any further write. Busy then lasts TIMEOUT_CYC+2 cycles. With lock arriving d cycles into the wait, busy lasts d+5 cycles.
- R4: The serializer configuration word always has bits 0, 16, 18 and 19 set. Bit 24 is also set exactly when f > 165 MHz.
- R5: When 250 MHz <= f <= 300 MHz, the trim value 0x1110 is ORed into the serializer configuration word. Before the OR, bits 0, 1, 16, 17, 18, 19 and 24 are cleared from the trim value.
- R6: After lock the block writes three registers on consecutive cycles and then pulses `done_o`:
  - 0x504 with the serializer configuration word.
  - 0x518 with 0.
  - 0x520 with 0.
- R7: An accepted stop first writes 0x504 with 0x000C0000, then writes 0x510 with 0. It then waits until `lock_i` is low, or for TIMEOUT_CYC cycles. If lock is still high at the end of the wait it pulses `err_o`, otherwise it pulses `done_o`.
- R8: Start and stop pulses that arrive while `busy_o` is high are ignored. If start and stop arrive together while idle, start wins.
- R9: `done_o` and `err_o` are one-cycle pulses that are never high together, and `busy_o` is low while either is high. `wr_en_o` is high only while `busy_o` is high.
- R10: After reset `busy_o`, `done_o`, `err_o` and `wr_en_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| pix_hz_i | input | 32 | Pixel clock frequency in Hz, sampled with start |
| lock_i | input | 1 | PLL lock status |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 12 | Register write address |
| wr_data_o | output | 32 | Register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished cleanly (one cycle) |
| err_o | output | 1 | Sequence failed (one cycle) |

## Verification
The assertions check the local rules on every cycle:
- Pulse shape and mutual exclusion of `done_o` and `err_o`.
- Writes occur only while busy.
- A rejected start raises an error without writing.
- The PLL word always carries the feedback divider of 40.
- The current-control write always follows the configuration write, and both zero writes carry zero.
- The shutdown PLL write follows the shutdown configuration write.
- Busy time has an upper bound.

Only the bench scenarios can show whether the divider codes and configuration bits are right for a given frequency. The bench sweeps every band edge, the 165 MHz and 250/300 MHz thresholds, and both timeout outcomes. It also covers the ignore and priority rules for overlapping commands, which show up only in the full write log.

// File: rtl/tmds_phy_pkg.sv
package tmds_phy_pkg;

  localparam int unsigned AW = 12;

  localparam logic [AW-1:0] A_SER_CFG = 12'h504;
  localparam logic [AW-1:0] A_PLL     = 12'h510;
  localparam logic [AW-1:0] A_ICTL    = 12'h518;
  localparam logic [AW-1:0] A_CAL     = 12'h520;

  localparam logic [7:0]  FB_DIV       = 8'd40;
  localparam logic [31:0] SER_BASE     = 32'h000D_0001;
  localparam logic [31:0] SER_SRC_TERM = 32'h0100_0000;
  localparam logic [31:0] SER_OWN_MASK = 32'h010F_0003;
  localparam logic [31:0] SER_TRIM_HI  = 32'h0000_1110;
  localparam logic [31:0] SER_PARKED   = 32'h000C_0000;

  localparam logic [31:0] F_B1 = 32'd20_000_000;
  localparam logic [31:0] F_B2 = 32'd42_500_000;
  localparam logic [31:0] F_B3 = 32'd85_000_000;
  localparam logic [31:0] F_B4 = 32'd170_000_000;
  localparam logic [31:0] F_MAX = 32'd340_000_000;
  localparam logic [31:0] F_SRC_TERM = 32'd165_000_000;
  localparam logic [31:0] F_TRIM_LO  = 32'd250_000_000;
  localparam logic [31:0] F_TRIM_HI  = 32'd300_000_000;

  typedef struct packed {
    logic       ok;
    logic [7:0] ref_div;
    logic [1:0] post_code;
  } div_sel_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PLL, S_LWAIT, S_LCHK, S_CFG, S_ICTL, S_CAL,
    S_SCFG, S_SPLL, S_UWAIT, S_UCHK
  } seq_st_t;

  function automatic div_sel_t band_lookup(input logic [31:0] f);
    div_sel_t s;
    s.ok = 1'b1;
    if (f < F_B1)       begin s.ref_div = 8'd1;  s.post_code = 2'd3; end
    else if (f < F_B2)  begin s.ref_div = 8'd2;  s.post_code = 2'd3; end
    else if (f < F_B3)  begin s.ref_div = 8'd4;  s.post_code = 2'd2; end
    else if (f < F_B4)  begin s.ref_div = 8'd8;  s.post_code = 2'd1; end
    else if (f < F_MAX) begin s.ref_div = 8'd16; s.post_code = 2'd0; end
    else begin s.ok = 1'b0; s.ref_div = 8'd0; s.post_code = 2'd0; end
    return s;
  endfunction

  function automatic logic [31:0] pll_word(input div_sel_t s, input logic en);
    return {6'd0, s.post_code, s.ref_div, FB_DIV, 7'd0, en};
  endfunction

  function automatic logic [31:0] ser_word(input logic [31:0] f);
    logic [31:0] v;
    v = SER_BASE;
    if (f > F_SRC_TERM) v = v | SER_SRC_TERM;
    if (f >= F_TRIM_LO && f <= F_TRIM_HI) v = v | (SER_TRIM_HI & ~SER_OWN_MASK);
    return v;
  endfunction

endpackage

// File: rtl/tmds_div_select.sv
module tmds_div_select
  import tmds_phy_pkg::*;
(
  input  logic [31:0] freq_i,
  output div_sel_t    sel_o
);
  always_comb sel_o = band_lookup(freq_i);
endmodule

// File: rtl/tmds_wait_timer.sv
module tmds_wait_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run_i)  cnt <= '0;
    else if (!expired_o) cnt <= cnt + 1'b1;
  end

  assign expired_o = run_i && (cnt == LAST);
endmodule

// File: rtl/tmds_phy_seq.sv
module tmds_phy_seq
  import tmds_phy_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 5_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic [31:0] pix_hz_i,
  input  logic        lock_i,
  output logic        wr_en_o,
  output logic [11:0] wr_addr_o,
  output logic [31:0] wr_data_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);

  seq_st_t     st;
  logic [31:0] f_q;
  div_sel_t    div_q;
  div_sel_t    sel_now;
  logic        in_wait;
  logic        tmr_exp;
  logic        accept_start;
  logic        reject_start;
  logic        accept_stop;

  tmds_div_select u_sel (
    .freq_i (pix_hz_i),
    .sel_o  (sel_now)
  );

  assign in_wait = (st == S_LWAIT) || (st == S_UWAIT);

  tmds_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (in_wait),
    .expired_o (tmr_exp)
  );

  assign accept_start = (st == S_IDLE) && start_i && sel_now.ok;
  assign reject_start = (st == S_IDLE) && start_i && !sel_now.ok;
  assign accept_stop  = (st == S_IDLE) && stop_i && !start_i;
  assign busy_o       = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      f_q    <= '0;
      div_q  <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (accept_start) begin
            st    <= S_PLL;
            f_q   <= pix_hz_i;
            div_q <= sel_now;
          end else if (reject_start) begin
            err_o <= 1'b1;
          end else if (accept_stop) begin
            st <= S_SCFG;
          end
        end
        S_PLL:   st <= S_LWAIT;
        S_LWAIT: if (lock_i || tmr_exp) st <= S_LCHK;
        S_LCHK: begin
          if (lock_i) st <= S_CFG;
          else begin
            err_o <= 1'b1;
            st    <= S_IDLE;
          end
        end
        S_CFG:  st <= S_ICTL;
        S_ICTL: st <= S_CAL;
        S_CAL: begin
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        S_SCFG:  st <= S_SPLL;
        S_SPLL:  st <= S_UWAIT;
        S_UWAIT: if (!lock_i || tmr_exp) st <= S_UCHK;
        S_UCHK: begin
          if (lock_i) err_o  <= 1'b1;
          else        done_o <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en_o   = 1'b0;
    wr_addr_o = '0;
    wr_data_o = '0;
    unique case (st)
      S_PLL:  begin wr_en_o = 1'b1; wr_addr_o = A_PLL;     wr_data_o = pll_word(div_q, 1'b1); end
      S_CFG:  begin wr_en_o = 1'b1; wr_addr_o = A_SER_CFG; wr_data_o = ser_word(f_q); end
      S_ICTL: begin wr_en_o = 1'b1; wr_addr_o = A_ICTL; end
      S_CAL:  begin wr_en_o = 1'b1; wr_addr_o = A_CAL; end
      S_SCFG: begin wr_en_o = 1'b1; wr_addr_o = A_SER_CFG; wr_data_o = SER_PARKED; end
      S_SPLL: begin wr_en_o = 1'b1; wr_addr_o = A_PLL; end
      default: ;
    endcase
  end

endmodule

// File: rtl/tmds_phy_seq_chk.sv
module tmds_phy_seq_chk #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en_o,
  input logic [11:0] wr_addr_o,
  input logic [31:0] wr_data_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        accept_start,
  input logic        reject_start
);

  logic [31:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1'b1;
    else             busy_run <= '0;
  end

  a_r1_fb_div: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o == 12'h510 && wr_data_o[0]) |-> (wr_data_o[15:8] == 8'd40));

  a_r2_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    reject_start |=> (err_o && !wr_en_o && !busy_o));

  a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= TIMEOUT_CYC + 6);

  a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o == 12'h518) |-> ($past(wr_en_o) && $past(wr_addr_o) == 12'h504));

  a_r6_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && (wr_addr_o == 12'h518 || wr_addr_o == 12'h520)) |-> (wr_data_o == 32'd0));

  a_r7_stop_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o == 12'h510 && wr_data_o == 32'd0)
      |-> ($past(wr_en_o) && $past(wr_data_o) == 32'h000C_0000));

  a_r8_start_first_write: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> (wr_en_o && wr_addr_o == 12'h510 && wr_data_o[0]));

  a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> !busy_o);

  a_r9_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o);

endmodule

bind tmds_phy_seq tmds_phy_seq_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .accept_start (accept_start),
  .reject_start (reject_start)
);

// File: tb/tmds_phy_seq_tb.sv
module tmds_phy_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [31:0] pix_hz_i = '0;
  logic        lock_q;
  logic        wr_en_o;
  logic [11:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic        busy_o, done_o, err_o;

  int n_tests = 0;
  int n_fail = 0;

  int  lock_dly = 2;
  bit  lock_never = 0;
  bit  lock_stuck = 0;
  int  on_cnt = 0;
  int  off_cnt = 0;

  logic [11:0] log_a [0:4095];
  logic [31:0] log_d [0:4095];
  int wn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmds_phy_seq #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .pix_hz_i(pix_hz_i), .lock_i(lock_q), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  // PLL model and write logger
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else begin
      if (on_cnt > 0) begin
        on_cnt = on_cnt - 1;
        if (on_cnt == 0 && !lock_never) lock_q <= 1'b1;
      end
      if (off_cnt > 0) begin
        off_cnt = off_cnt - 1;
        if (off_cnt == 0 && !lock_stuck) lock_q <= 1'b0;
      end
      if (wr_en_o) begin
        if (wn < 4096) begin
          log_a[wn] = wr_addr_o;
          log_d[wn] = wr_data_o;
        end
        wn = wn + 1;
        if (wr_addr_o == 12'h510) begin
          if (wr_data_o[0]) on_cnt = lock_dly;
          else              off_cnt = lock_dly;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pll(input logic [31:0] f);
    int idx = 0;
    logic [7:0] rd;
    logic [1:0] pc;
    if (f >= 32'd20_000_000)  idx++;
    if (f >= 32'd42_500_000)  idx++;
    if (f >= 32'd85_000_000)  idx++;
    if (f >= 32'd170_000_000) idx++;
    rd = 8'(1 << idx);
    pc = (idx <= 1) ? 2'd3 : 2'(4 - idx);
    return (32'(pc) << 24) | (32'(rd) << 16) | (32'd40 << 8) | 32'd1;
  endfunction

  function automatic logic [31:0] exp_cfg(input logic [31:0] f);
    logic [31:0] v = (32'd1 << 0) | (32'd1 << 16) | (32'd1 << 18) | (32'd1 << 19);
    if (f > 32'd165_000_000) v = v + (32'd1 << 24);
    if (f >= 32'd250_000_000 && f <= 32'd300_000_000) v = v | 32'h1110;
    return v;
  endfunction

  task automatic run(input bit is_start, input bit is_stop, input logic [31:0] f,
                     output bit gd, output bit ge, output int bc, output int base);
    base = wn;
    @(negedge clk);
    start_i = is_start; stop_i = is_stop; pix_hz_i = f;
    @(negedge clk);
    start_i = 0; stop_i = 0;
    gd = 0; ge = 0; bc = 0;
    for (int k = 0; k < 400; k++) begin
      if (busy_o) bc++;
      if (done_o) gd = 1;
      if (err_o)  ge = 1;
      if (gd || ge) break;
      @(negedge clk);
    end
  endtask

  task automatic check_start_ok(input logic [31:0] f, input int bc_exp);
    bit gd, ge; int bc, b;
    run(1, 0, f, gd, ge, bc, b);
    chk(gd && !ge, "R6 done", {30'd0, ge, gd}, 32'd1);
    chk(wn - b == 4, "R6 write count", 32'(wn - b), 32'd4);
    chk(log_a[b] == 12'h510 && log_d[b] == exp_pll(f), "R1 pll word", log_d[b], exp_pll(f));
    chk(log_a[b+1] == 12'h504 && log_d[b+1] == exp_cfg(f), "R4 R5 cfg word", log_d[b+1], exp_cfg(f));
    chk(log_a[b+2] == 12'h518 && log_d[b+2] == 0, "R6 ictl", {20'd0, log_a[b+2]}, 32'h518);
    chk(log_a[b+3] == 12'h520 && log_d[b+3] == 0, "R6 cal", {20'd0, log_a[b+3]}, 32'h520);
    if (bc_exp > 0) chk(bc == bc_exp, "R3 busy length", 32'(bc), 32'(bc_exp));
  endtask

  task automatic check_stop_ok();
    bit gd, ge; int bc, b;
    run(0, 1, 0, gd, ge, bc, b);
    chk(gd && !ge, "R7 stop done", {30'd0, ge, gd}, 32'd1);
    chk(wn - b == 2 && log_a[b] == 12'h504 && log_d[b] == 32'h000C_0000,
        "R7 stop cfg", log_d[b], 32'h000C_0000);
    chk(log_a[b+1] == 12'h510 && log_d[b+1] == 0, "R7 stop pll", log_d[b+1], 32'd0);
    chk(bc == lock_dly + 3, "R7 stop busy", 32'(bc), 32'(lock_dly + 3));
  endtask

  logic [31:0] freqs [0:17] = '{
    32'd0, 32'd19_999_999, 32'd20_000_000, 32'd42_499_999, 32'd42_500_000,
    32'd84_999_999, 32'd85_000_000, 32'd165_000_000, 32'd165_000_001,
    32'd169_999_999, 32'd170_000_000, 32'd249_999_999, 32'd250_000_000,
    32'd275_000_000, 32'd300_000_000, 32'd300_000_001, 32'd339_999_999, 32'd74_250_000
  };

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    bit gd, ge; int bc, b;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !wr_en_o, "R10 reset",
        {28'd0, busy_o, done_o, err_o, wr_en_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !wr_en_o, "R10 after release",
        {28'd0, busy_o, done_o, err_o, wr_en_o}, 32'd0);

    // R1 R4 R5 R6 band sweep; R3 early exit busy length d+5
    foreach (freqs[i]) begin
      lock_dly = 2 + (i % 4);
      check_start_ok(freqs[i], lock_dly + 5);
      check_stop_ok();
    end

    // R2 out of range
    begin
      logic [31:0] bad [0:2] = '{32'd340_000_000, 32'd340_000_001, 32'hFFFF_FFFF};
      foreach (bad[i]) begin
        run(1, 0, bad[i], gd, ge, bc, b);
        chk(ge && !gd, "R2 error", {30'd0, ge, gd}, 32'd2);
        chk(wn == b, "R2 no write", 32'(wn - b), 32'd0);
        chk(bc == 0, "R2 not busy", 32'(bc), 32'd0);
      end
    end

    // R3 timeout without lock
    lock_never = 1;
    run(1, 0, 32'd100_000_000, gd, ge, bc, b);
    chk(ge && !gd, "R3 timeout error", {30'd0, ge, gd}, 32'd2);
    chk(wn - b == 1, "R3 only pll write", 32'(wn - b), 32'd1);
    chk(bc == TMO + 2, "R3 timeout busy", 32'(bc), 32'(TMO + 2));
    lock_never = 0;

    // R7 stop with lock stuck high
    lock_dly = 2;
    check_start_ok(32'd148_500_000, 7);
    lock_stuck = 1;
    run(0, 1, 0, gd, ge, bc, b);
    chk(ge && !gd, "R7 stuck lock error", {30'd0, ge, gd}, 32'd2);
    chk(bc == TMO + 3, "R7 stuck busy", 32'(bc), 32'(TMO + 3));
    lock_stuck = 0;
    off_cnt = 0;
    check_stop_ok();

    // R8 commands while busy are ignored
    lock_dly = 6;
    b = wn;
    @(negedge clk); start_i = 1; pix_hz_i = 32'd27_000_000;
    @(negedge clk); start_i = 0;
    repeat (2) @(negedge clk);
    start_i = 1; stop_i = 1; pix_hz_i = 32'd297_000_000;
    @(negedge clk); start_i = 0; stop_i = 0;
    gd = 0;
    for (int k = 0; k < 100 && !gd; k++) begin
      if (done_o) gd = 1;
      else @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk(wn - b == 4, "R8 busy ignore count", 32'(wn - b), 32'd4);
    chk(log_d[b] == exp_pll(32'd27_000_000), "R8 busy ignore pll", log_d[b], exp_pll(32'd27_000_000));
    chk(log_d[b+1] == exp_cfg(32'd27_000_000), "R8 busy ignore cfg", log_d[b+1], exp_cfg(32'd27_000_000));
    chk(!busy_o, "R8 idle after", {31'd0, busy_o}, 32'd0);

    // R8 start wins over stop
    lock_dly = 2;
    run(1, 1, 32'd54_000_000, gd, ge, bc, b);
    chk(gd && log_a[b] == 12'h510 && log_d[b] == exp_pll(32'd54_000_000),
        "R8 start priority", log_d[b], exp_pll(32'd54_000_000));

    // R9 done is a single-cycle pulse
    @(negedge clk);
    chk(!done_o && !err_o && !busy_o, "R9 pulse width", {29'd0, done_o, err_o, busy_o}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule